// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a scan chain built from pairs of level-sensitive latches, together with the sequencer that drives it. Each stage has two latches. The first latch has two data ports: a functional port, loaded while clock phase C is high, and a scan port, loaded while clock phase A is high. The second latch copies the first while clock phase B is high. The three phases decide what the chain does, so there is no scan-enable signal. C followed by B captures functional data, which is normal operation. A followed by B moves every bit one stage toward the serial output. A and B high together make the whole chain transparent, which is the flush mode used to self-test the latches.

The sequencer runs on a fast system clock and produces the phases as enables from a decoded state register. Every phase pulse lasts one clock, and at least one idle clock with all phases low separates two pulses. A one-clock `start` launches one of four operations:

- a flush test,
- a plain shift,
- a capture followed by a full shift-out,
- a capture alone.

During the shift operations the sequencer records the serial output before each shift. At the end it compares the recorded word against an expected vector and raises `done` for one clock with the result on `match`.

The sequencer's states are:

- `S_IDLE` waits for `start`.
- `S_FLUSH` holds A and B high for `FLUSH_LEN` clocks.
- `S_FL_GAP` drops all phases after a flush.
- `S_CAP_C` pulses C, and `S_GAP_C` idles after it.
- `S_CAP_B` pulses B, and `S_GAP_CB` idles after it.
- `S_SH_A` pulses A, and `S_GAP_A` idles after it.
- `S_SH_B` pulses B, and `S_GAP_B` idles after it.
- `S_DONE` marks the end of an operation.

The transitions are:

- `S_IDLE` goes to `S_FLUSH`, `S_SH_A` or `S_CAP_C` on `start`, chosen by the operation code.
- `S_FLUSH` loops until its counter ends, then goes to `S_FL_GAP` and then `S_DONE`.
- `S_CAP_C` goes to `S_GAP_C`, then `S_CAP_B`, then `S_GAP_CB`.
- `S_GAP_CB` goes to `S_DONE` for a capture alone, and to `S_SH_A` otherwise.
- `S_SH_A` goes to `S_GAP_A`, then `S_SH_B`, then `S_GAP_B`.
- `S_GAP_B` returns to `S_SH_A` until N shifts are done, then goes to `S_DONE`.
- `S_DONE` returns to `S_IDLE`.

Top module: `lssd_chain_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all phases, `done`, `match`, `state_q` and `scan_out` are 0.
- R2: Phase A is never high together with phase C, and phase B is never high together with phase C.
- R3: A phase may turn on only if, in the previous clock, none of the other phases was high.
- R4: `state_q` (the second latches) changes only during a clock in which phase B is high.
- R5: Each A pulse loads stage 0's first latch from `scan_in` and stage i's first latch from stage i-1's second latch. The following B pulse copies every first latch into its second latch. `scan_out` is stage N-1's second latch.
- R6: A C pulse loads every first latch from `func_d` (bit i into stage i), and the following B pulse shows it on `state_q`.
- R7: In a shift operation, `scan_out` is sampled before each of the N A pulses. `match` is 1 exactly when the sampled word equals `exp_vec`, where bit i of `exp_vec` is stage i's content before the first shift.
- R8: A flush holds A and B high together for `FLUSH_LEN` clocks, and `scan_out` follows `scan_in` during that time. `match` is 1 when they were equal at every clock edge of the flush.
- R9: Every operation ends with `done` high for exactly one clock. A `start` that arrives while an operation runs is ignored.
- R10: The operation codes on `op` are:
  - 2'b00: flush.
  - 2'b01: shift, giving N A/B pulse pairs.
  - 2'b10: capture, with one C pulse then one B pulse, followed by N A/B pairs.
  - 2'b11: capture only, which ends with `match` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the sequencer |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin an operation |
| op | input | 2 | Operation code, sampled with `start` |
| exp_vec | input | N | Expected stage contents for the shift compare |
| scan_in | input | 1 | Serial data into stage 0's scan port |
| func_d | input | N | Functional data for the first latches |
| state_q | output | N | Second-latch contents (the functional outputs) |
| scan_out | output | 1 | Second latch of the last stage |
| ph_a | output | 1 | Scan load phase |
| ph_b | output | 1 | Second-latch transfer phase |
| ph_c | output | 1 | Functional load phase |
| done | output | 1 | One-clock end-of-operation pulse |
| match | output | 1 | Compare result, valid from `done` |

## Verification
In flush mode `scan_in` alternates on every clock, which shows whether the chain is really transparent end to end and not one stage deep. Shifts use a pseudo-random serial stream on top of whatever data the chain holds, which exposes stage order and dropped or doubled bits. A capture with a known `func_d` tells the functional port apart from the scan port. Running the same capture against a corrupted `exp_vec` proves that `match` can go low. A `start` poked in the middle of an operation, together with counting the phase pulses of each operation, separates correct sequencing from extra or missing pulses.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

    typedef enum logic [1:0] {
        OP_FLUSH   = 2'b00,
        OP_SHIFT   = 2'b01,
        OP_CAPSH   = 2'b10,
        OP_CAPONLY = 2'b11
    } op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FLUSH,
        S_FL_GAP,
        S_CAP_C,
        S_GAP_C,
        S_CAP_B,
        S_GAP_CB,
        S_SH_A,
        S_GAP_A,
        S_SH_B,
        S_GAP_B,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } phases_t;

endpackage

// File: rtl/lssd_cell.sv
module lssd_cell (
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    input  logic ph_c,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);
    logic mst;

    // two-port first latch: functional port on C, scan port on A
    always_latch begin
        if (!rst_n)
            mst = 1'b0;
        else if (ph_c)
            mst = d_func;
        else if (ph_a)
            mst = d_scan;
    end

    // second latch follows the first while B is high
    always_latch begin
        if (!rst_n)
            q = 1'b0;
        else if (ph_b)
            q = mst;
    end
endmodule

// File: rtl/lssd_chain.sv
module lssd_chain #(
    parameter int N = 8
) (
    input  logic         rst_n,
    input  logic         ph_a,
    input  logic         ph_b,
    input  logic         ph_c,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] state_q,
    output logic         scan_out
);
    logic [N:0] link;

    assign link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_stage
        lssd_cell u_cell (
            .rst_n (rst_n),
            .ph_a  (ph_a),
            .ph_b  (ph_b),
            .ph_c  (ph_c),
            .d_func(func_d[i]),
            .d_scan(link[i]),
            .q     (link[i+1])
        );
        assign state_q[i] = link[i+1];
    end

    assign scan_out = link[N];
endmodule

// File: rtl/lssd_seq.sv
module lssd_seq
    import lssd_pkg::*;
#(
    parameter int N         = 8,
    parameter int FLUSH_LEN = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [N-1:0] exp_vec,
    input  logic         scan_in,
    input  logic         scan_out,
    output logic         ph_a,
    output logic         ph_b,
    output logic         ph_c,
    output logic         done,
    output logic         match
);
    localparam int MAXC = (N > FLUSH_LEN) ? N : FLUSH_LEN;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] LAST_SH = CW'(N - 1);
    localparam logic [CW-1:0] LAST_FL = CW'(FLUSH_LEN - 1);

    seq_state_t   st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    op_t          op_q;
    logic [N-1:0] exp_q;
    logic [N-1:0] obs;
    logic         ok;
    logic         match_q;
    logic         enter_sh_a;
    logic         enter_done;
    phases_t      ph;

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            S_IDLE: begin
                cnt_nx = '0;
                if (start) begin
                    unique case (op_t'(op))
                        OP_FLUSH:   st_nx = S_FLUSH;
                        OP_SHIFT:   st_nx = S_SH_A;
                        OP_CAPSH,
                        OP_CAPONLY: st_nx = S_CAP_C;
                    endcase
                end
            end
            S_FLUSH: begin
                if (cnt == LAST_FL) begin
                    st_nx  = S_FL_GAP;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            S_FL_GAP: st_nx = S_DONE;
            S_CAP_C:  st_nx = S_GAP_C;
            S_GAP_C:  st_nx = S_CAP_B;
            S_CAP_B:  st_nx = S_GAP_CB;
            S_GAP_CB: st_nx = (op_q == OP_CAPONLY) ? S_DONE : S_SH_A;
            S_SH_A:   st_nx = S_GAP_A;
            S_GAP_A:  st_nx = S_SH_B;
            S_SH_B:   st_nx = S_GAP_B;
            S_GAP_B: begin
                if (cnt == LAST_SH) begin
                    st_nx  = S_DONE;
                    cnt_nx = '0;
                end else begin
                    st_nx  = S_SH_A;
                    cnt_nx = cnt + 1'b1;
                end
            end
            S_DONE:   st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    assign enter_sh_a = (st_nx == S_SH_A) && (st != S_SH_A);
    assign enter_done = (st_nx == S_DONE) && (st != S_DONE);

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            op_q    <= OP_FLUSH;
            exp_q   <= '0;
            obs     <= '0;
            ok      <= 1'b0;
            match_q <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (st == S_IDLE && start) begin
                op_q    <= op_t'(op);
                exp_q   <= exp_vec;
                ok      <= 1'b1;
                match_q <= 1'b0;
            end
            if (st == S_FLUSH)
                ok <= ok & (scan_out == scan_in);
            if (enter_sh_a)
                obs <= {obs[N-2:0], scan_out};
            if (enter_done) begin
                unique case (op_q)
                    OP_FLUSH:   match_q <= ok;
                    OP_CAPONLY: match_q <= 1'b0;
                    OP_SHIFT,
                    OP_CAPSH:   match_q <= (obs == exp_q);
                endcase
            end
        end
    end

    // phase and status outputs, decoded from the state register
    always_comb begin
        ph = '0;
        unique case (st)
            S_FLUSH:  ph = '{a: 1'b1, b: 1'b1, c: 1'b0};
            S_CAP_C:  ph.c = 1'b1;
            S_CAP_B,
            S_SH_B:   ph.b = 1'b1;
            S_SH_A:   ph.a = 1'b1;
            default:  ph = '0;
        endcase
    end

    assign ph_a  = ph.a;
    assign ph_b  = ph.b;
    assign ph_c  = ph.c;
    assign done  = (st == S_DONE);
    assign match = match_q;
endmodule

// File: rtl/lssd_chain_top.sv
module lssd_chain_top #(
    parameter int N         = 8,
    parameter int FLUSH_LEN = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [N-1:0] exp_vec,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] state_q,
    output logic         scan_out,
    output logic         ph_a,
    output logic         ph_b,
    output logic         ph_c,
    output logic         done,
    output logic         match
);
    lssd_seq #(
        .N        (N),
        .FLUSH_LEN(FLUSH_LEN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .exp_vec (exp_vec),
        .scan_in (scan_in),
        .scan_out(scan_out),
        .ph_a    (ph_a),
        .ph_b    (ph_b),
        .ph_c    (ph_c),
        .done    (done),
        .match   (match)
    );

    lssd_chain #(
        .N(N)
    ) u_chain (
        .rst_n   (rst_n),
        .ph_a    (ph_a),
        .ph_b    (ph_b),
        .ph_c    (ph_c),
        .scan_in (scan_in),
        .func_d  (func_d),
        .state_q (state_q),
        .scan_out(scan_out)
    );
endmodule

// File: rtl/lssd_chk.sv
module lssd_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ph_a,
    input logic         ph_b,
    input logic         ph_c,
    input logic         done,
    input logic [N-1:0] state_q
);
    assert_no_a_with_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_a && ph_c));

    assert_no_b_with_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_b && ph_c));

    assert_gap_before_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_a && !$past(ph_a)) |-> (!$past(ph_b) && !$past(ph_c)));

    assert_gap_before_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_b && !$past(ph_b)) |-> (!$past(ph_a) && !$past(ph_c)));

    assert_gap_before_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_c && !$past(ph_c)) |-> (!$past(ph_a) && !$past(ph_b)));

    assert_hold_without_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_b |-> $stable(state_q));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind lssd_chain_top lssd_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph_a   (ph_a),
    .ph_b   (ph_b),
    .ph_c   (ph_c),
    .done   (done),
    .state_q(state_q)
);

// File: tb/tb_lssd_chain_top.sv
module tb_lssd_chain_top;
    localparam int N         = 8;
    localparam int FLUSH_LEN = 6;
    localparam int PERIOD    = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [N-1:0] exp_vec = '0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] state_q;
    logic         scan_out, ph_a, ph_b, ph_c, done, match;

    int checks = 0;
    int errors = 0;

    // reference model state: first and second latch of every stage
    logic [N-1:0] mm = '0;
    logic [N-1:0] ms = '0;
    logic [15:0]  lfsr = 16'hACE1;
    logic pa = 0, pb = 0, pc = 0;
    int cnt_a = 0, cnt_b = 0, cnt_c = 0, cnt_done = 0;

    lssd_chain_top #(.N(N), .FLUSH_LEN(FLUSH_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .exp_vec(exp_vec),
        .scan_in(scan_in), .func_d(func_d), .state_q(state_q), .scan_out(scan_out),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .done(done), .match(match)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // per-cycle stimulus on scan_in, model update and compare
    always @(negedge clk) begin
        if (ph_a && ph_b) scan_in <= ~scan_in;       // alternating during flush
        else begin
            lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            scan_in <= lfsr[0];
        end
        #1;
        if (!rst_n) begin
            mm = '0;
            ms = '0;
            chk(ph_a == 0 && ph_b == 0 && ph_c == 0 && done == 0 && match == 0,
                "R1 reset outputs", {ph_a, ph_b, ph_c, done, match}, 0);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ph_c) mm[i] = func_d[i];
                else if (ph_a) mm[i] = (i == 0) ? scan_in : ms[i-1];
                if (ph_b) ms[i] = mm[i];
            end
            chk(!(ph_c && (ph_a || ph_b)), "R2 phase overlap", {ph_a, ph_b, ph_c}, 0);
            if (ph_a && !pa) chk(!pb && !pc, "R3 gap before A", {pb, pc}, 0);
            if (ph_b && !pb) chk(!pa && !pc, "R3 gap before B", {pa, pc}, 0);
            if (ph_c && !pc) chk(!pa && !pb, "R3 gap before C", {pa, pb}, 0);
            if (ph_a && !pa) cnt_a++;
            if (ph_b && !pb) cnt_b++;
            if (ph_c && !pc) cnt_c++;
            if (done) cnt_done++;
        end
        chk(state_q == ms, "R4/R5/R6 state_q vs model", state_q, ms);
        chk(scan_out == ms[N-1], "R5 scan_out vs last stage", scan_out, ms[N-1]);
        if (rst_n && ph_a && ph_b)
            chk(scan_out == scan_in, "R8 flush transparency", scan_out, scan_in);
        pa = ph_a; pb = ph_b; pc = ph_c;
    end

    task automatic run_op(input logic [1:0] o, input logic [N-1:0] e, input bit exp_m,
                          input int ea, input int eb, input int ec, input bit poke,
                          input string req);
        @(negedge clk);
        op = o; exp_vec = e; start = 1'b1;
        cnt_a = 0; cnt_b = 0; cnt_c = 0; cnt_done = 0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            #2;
            if (poke && k == 5) start = 1'b1;
            if (poke && k == 6) start = 1'b0;
            if (done) break;
        end
        #2;
        chk(done == 1'b1, {req, " done seen (R9)"}, done, 1);
        chk(match == exp_m, {req, " match"}, match, exp_m);
        chk(cnt_a == ea && cnt_b == eb && cnt_c == ec, {req, " pulse counts (R10)"},
            cnt_a * 10000 + cnt_b * 100 + cnt_c, ea * 10000 + eb * 100 + ec);
        @(negedge clk);
        #2;
        chk(done == 1'b0 && cnt_done == 1, {req, " single done R9"}, cnt_done, 1);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(state_q == '0 && scan_out == 0, "R1 reset chain", state_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(ph_a == 0 && ph_b == 0 && ph_c == 0 && done == 0, "R1 after release",
            {ph_a, ph_b, ph_c, done}, 0);

        // R8 flush test with alternating scan_in
        run_op(2'b00, '0, 1'b1, 1, 1, 0, 1'b0, "R8 flush");

        // R5 R7 plain shift: expected word is the chain content now
        run_op(2'b01, ms, 1'b1, N, N, 0, 1'b0, "R5 R7 shift");
        run_op(2'b01, ms, 1'b1, N, N, 0, 1'b0, "R5 R7 shift again");

        // R6 capture then shift out
        func_d = 8'hA5;
        run_op(2'b10, 8'hA5, 1'b1, N, N + 1, 1, 1'b0, "R6 capture-shift");
        func_d = 8'h3C;
        run_op(2'b10, 8'h3D, 1'b0, N, N + 1, 1, 1'b0, "R7 wrong expectation");

        // R10 capture only
        func_d = 8'hC3;
        run_op(2'b11, '0, 1'b0, 0, 1, 1, 1'b0, "R10 capture-only");
        chk(state_q == 8'hC3, "R6 capture-only state_q", state_q, 8'hC3);

        // R9 start poked while busy is ignored
        func_d = 8'h5A;
        run_op(2'b10, 8'h5A, 1'b1, N, N + 1, 1, 1'b1, "R9 poke during op");
        run_op(2'b00, '0, 1'b1, 1, 1, 0, 1'b1, "R9 R8 poke during flush");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule